// File: doc/BRIEF.md
# Accumulator Rounding and Saturation Stage

This block post-processes a 44-bit two's-complement accumulator word before it is handed to a narrower consumer. Two independent steps can be switched on per sample: rounding, which drops everything below a build-time bit position and rounds to the nearest representable value, and saturation, which clamps the result into the signed range of a build-time width. If both are on, the clamp sees the already-rounded value.

Two parameters fix the behaviour at build time:

- **Rounding style:** half-up or half-to-even.
- **Clamp style:** asymmetric or symmetric.

The retained least significant bit sits at `RND_POS`, which can be anywhere from bit 6 to bit 21. The clamp boundary is `SAT_POS`, which can be anywhere from bit 28 to bit 43. A single register stage carries a valid bit alongside the data. A flag reports every sample that the clamp altered.

Top module: `rsu_unit`

## Requirements
- R1: After reset, `out_valid`, `out_data` and `out_sat_ovf` are all zero.
- R2: Output latency is one clock.
  - `out_valid` is `in_valid` delayed one clock.
  - A sample accepted with `in_valid` high appears on `out_data` and `out_sat_ovf` one clock later.
  - While `in_valid` is low, the outputs hold their previous values.
- R3: With `rnd_en` = 0 and `sat_en` = 0, `out_data` equals the accepted `in_data` and `out_sat_ovf` is 0.
- R4: With `rnd_en` = 1 and half-up rounding, the result is `in_data` + 2^(RND_POS-1), with bits `RND_POS-1..0` then cleared. A tie therefore moves toward plus infinity. Bits below `RND_POS` are always zero in a rounded result.
- R5: With half-to-even rounding, non-tie inputs round as in R4. At an exact tie (the dropped bits are 1 followed by zeros), the result is the neighbour whose bit `RND_POS` is 0.
- R6: With `sat_en` = 1 and the asymmetric clamp, the result is limited to -2^SAT_POS ... 2^SAT_POS - L. L is 1 when `rnd_en` = 0 and 2^RND_POS when `rnd_en` = 1. The result is sign-extended to 44 bits.
- R7: With `sat_en` = 1 and the symmetric clamp, the lower limit is -(2^SAT_POS - L), the negation of the upper limit. L is the same as in R6.
- R8: Saturation is applied to the rounded value. A value that rounding pushes past the upper limit is clamped and flagged.
- R9: `out_sat_ovf` is 1 exactly when `sat_en` was 1 and the clamp changed the value. It is 0 whenever `sat_en` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 44 | Two's-complement input word |
| rnd_en | input | 1 | 1 enables rounding for this sample |
| sat_en | input | 1 | 1 enables saturation for this sample |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | 44 | Processed word, sign-extended |
| out_sat_ovf | output | 1 | Clamp altered this sample |

## Verification
The hardest condition to reach is a sample that lies inside the clamp range before rounding but crosses the limit only because of the rounding carry. Exact rounding ties are the next hardest. Uniformly random 44-bit words almost never produce either case.

The stimulus therefore builds these values on purpose:

- **Ties:** the dropped bits are forced to the half pattern while the kept bit 0 is randomized.
- **Carry past the limit:** values are set just below 2^SAT_POS and just above -2^SAT_POS.
- **General coverage:** random values are scaled by a random arithmetic shift so that most of them land near the clamp boundary instead of far beyond it.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
   localparam int WORD_W      = 44;
   localparam int RND_POS_MIN = 6;
   localparam int RND_POS_MAX = 21;
   localparam int SAT_POS_MIN = 28;
   localparam int SAT_POS_MAX = 43;

   typedef enum logic {
      RND_HALF_UP   = 1'b0,
      RND_HALF_EVEN = 1'b1
   } rnd_kind_e;

   typedef enum logic {
      SAT_ASYM = 1'b0,
      SAT_SYM  = 1'b1
   } sat_kind_e;
endpackage

// File: rtl/rsu_round.sv
module rsu_round #(
   parameter int               W    = 44,
   parameter int               P    = 15,
   parameter rsu_pkg::rnd_kind_e KIND = rsu_pkg::RND_HALF_UP
) (
   input  logic [W-1:0] din,
   input  logic         en,
   output logic [W:0]   dout
);
   localparam logic [W:0] ONE_X  = {{W{1'b0}}, 1'b1};
   localparam logic [W:0] HALF   = ONE_X << (P - 1);
   localparam logic [W:0] KEEP_M = ~((ONE_X << P) - ONE_X);

   logic [W:0] ext;
   logic [W:0] bumped;
   logic [W:0] chosen;
   logic       tie;

   assign ext    = {din[W-1], din};
   assign bumped = ext + HALF;
   assign tie    = (din[P-1:0] == HALF[P-1:0]);

   generate
      if (KIND == rsu_pkg::RND_HALF_EVEN) begin : g_even
         // exact tie with even kept LSB: truncation already gives the even neighbour
         assign chosen = (tie && !din[P]) ? ext : bumped;
      end else begin : g_half_up
         assign chosen = bumped;
      end
   endgenerate

   assign dout = en ? (chosen & KEEP_M) : ext;
endmodule

// File: rtl/rsu_sat.sv
module rsu_sat #(
   parameter int                 W    = 44,
   parameter int                 S    = 35,
   parameter int                 P    = 15,
   parameter rsu_pkg::sat_kind_e KIND = rsu_pkg::SAT_ASYM
) (
   input  logic [W:0]   val,
   input  logic         en,
   input  logic         rnd_en,
   output logic [W-1:0] dout,
   output logic         ovf
);
   localparam logic signed [W+1:0] ONE_S  = {{(W+1){1'b0}}, 1'b1};
   localparam logic signed [W+1:0] TOP_V  = ONE_S <<< S;
   localparam logic signed [W+1:0] HI_RND = TOP_V - (ONE_S <<< P);
   localparam logic signed [W+1:0] HI_RAW = TOP_V - ONE_S;

   logic signed [W+1:0] vs;
   logic signed [W+1:0] hi;
   logic signed [W+1:0] lo;

   assign vs = {val[W], val};
   assign hi = rnd_en ? HI_RND : HI_RAW;

   generate
      if (KIND == rsu_pkg::SAT_SYM) begin : g_sym
         assign lo = -hi;
      end else begin : g_asym
         assign lo = -TOP_V;
      end
   endgenerate

   always_comb begin
      dout = val[W-1:0];
      ovf  = 1'b0;
      if (en) begin
         if (vs > hi) begin
            dout = hi[W-1:0];
            ovf  = 1'b1;
         end else if (vs < lo) begin
            dout = lo[W-1:0];
            ovf  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/rsu_unit.sv
module rsu_unit #(
   parameter int                 DATA_W   = rsu_pkg::WORD_W,
   parameter int                 RND_POS  = 15,
   parameter int                 SAT_POS  = 35,
   parameter rsu_pkg::rnd_kind_e RND_KIND = rsu_pkg::RND_HALF_UP,
   parameter rsu_pkg::sat_kind_e SAT_KIND = rsu_pkg::SAT_ASYM
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              rnd_en,
   input  logic              sat_en,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sat_ovf
);
   localparam logic signed [DATA_W+1:0] ONE_S  = {{(DATA_W+1){1'b0}}, 1'b1};
   localparam logic signed [DATA_W+1:0] TOP_V  = ONE_S <<< SAT_POS;
   localparam logic signed [DATA_W+1:0] HI_RND = TOP_V - (ONE_S <<< RND_POS);
   localparam logic signed [DATA_W+1:0] HI_RAW = TOP_V - ONE_S;

   generate
      if (DATA_W != rsu_pkg::WORD_W) begin : g_bad_width
         $error("rsu_unit: DATA_W must be %0d", rsu_pkg::WORD_W);
      end
      if (RND_POS < rsu_pkg::RND_POS_MIN || RND_POS > rsu_pkg::RND_POS_MAX) begin : g_bad_rnd
         $error("rsu_unit: RND_POS %0d outside window", RND_POS);
      end
      if (SAT_POS < rsu_pkg::SAT_POS_MIN || SAT_POS > rsu_pkg::SAT_POS_MAX) begin : g_bad_sat
         $error("rsu_unit: SAT_POS %0d outside window", SAT_POS);
      end
   endgenerate

   logic [DATA_W:0]   rounded;
   logic [DATA_W-1:0] clamped;
   logic              clamp_hit;

   rsu_round #(.W(DATA_W), .P(RND_POS), .KIND(RND_KIND)) u_round (
      .din  (in_data),
      .en   (rnd_en),
      .dout (rounded)
   );

   rsu_sat #(.W(DATA_W), .S(SAT_POS), .P(RND_POS), .KIND(SAT_KIND)) u_sat (
      .val    (rounded),
      .en     (sat_en),
      .rnd_en (rnd_en),
      .dout   (clamped),
      .ovf    (clamp_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_data    <= '0;
         out_sat_ovf <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data    <= clamped;
            out_sat_ovf <= clamp_hit;
         end
      end
   end

   // R2: valid follows the input one clock later; idle cycles hold data
   p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_data) && $stable(out_sat_ovf) && !out_valid));

   // R3: both functions off means pass-through
   p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !rnd_en && !sat_en) |=> (out_data == $past(in_data)));

   // R4: rounded results carry no bits below the rounding position
   p_low_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rnd_en) |=> (out_data[RND_POS-1:0] == '0));

   // R6: upper clamp limit never exceeded
   p_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sat_en) |=>
         ($signed(out_data) <= ($past(rnd_en) ? HI_RND : HI_RAW)));

   // R9: no overflow report without saturation
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !sat_en) |=> !out_sat_ovf);

   generate
      if (SAT_KIND == rsu_pkg::SAT_SYM) begin : g_chk_sym
         // R7: symmetric lower limit mirrors the upper one
         p_lower_sym_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sat_en) |=>
               ($signed(out_data) >= -($past(rnd_en) ? HI_RND : HI_RAW)));
      end else begin : g_chk_asym
         // R6: asymmetric lower limit
         p_lower_asym_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sat_en) |=> ($signed(out_data) >= -TOP_V));
      end
   endgenerate
endmodule

// File: tb/tb_rsu_unit.sv
module tb_rsu_unit;
   localparam int CLK_PERIOD = 10;
   localparam int RP = 15;
   localparam int SP = 35;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [43:0] in_data = '0;
   logic        rnd_en = 1'b0;
   logic        sat_en = 1'b0;
   logic        ov_a, ov_b, vl_a, vl_b;
   logic [43:0] od_a, od_b;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rsu_unit #(.RND_POS(RP), .SAT_POS(SP),
              .RND_KIND(rsu_pkg::RND_HALF_UP), .SAT_KIND(rsu_pkg::SAT_ASYM)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .rnd_en(rnd_en), .sat_en(sat_en),
      .out_valid(vl_a), .out_data(od_a), .out_sat_ovf(ov_a));

   rsu_unit #(.RND_POS(RP), .SAT_POS(SP),
              .RND_KIND(rsu_pkg::RND_HALF_EVEN), .SAT_KIND(rsu_pkg::SAT_SYM)) dut_alt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .rnd_en(rnd_en), .sat_en(sat_en),
      .out_valid(vl_b), .out_data(od_b), .out_sat_ovf(ov_b));

   function automatic logic [44:0] model(logic [43:0] d, bit r, bit s, bit even, bit sym);
      longint v, q, rem, half, top, lsb, hi, lo;
      bit     ov;
      ov = 1'b0;
      v  = longint'($signed(d));
      if (r) begin
         q    = v >>> RP;
         rem  = v - (q <<< RP);
         half = 64'sd1 <<< (RP - 1);
         if (rem > half || (rem == half && (!even || q[0]))) q = q + 1;
         v = q <<< RP;
      end
      if (s) begin
         top = 64'sd1 <<< SP;
         lsb = r ? (64'sd1 <<< RP) : 64'sd1;
         hi  = top - lsb;
         lo  = sym ? -hi : -top;
         if (v > hi) begin v = hi; ov = 1'b1; end
         else if (v < lo) begin v = lo; ov = 1'b1; end
      end
      return {ov, v[43:0]};
   endfunction

   task automatic cmp(string req, string what, logic [44:0] act, logic [44:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual ovf=%0b data=%h expected ovf=%0b data=%h",
                  req, what, act[44], act[43:0], exp[44], exp[43:0]);
      end
   endtask

   // drive one sample at a falling edge, check both variants at the next falling edge
   task automatic sample(string req, logic [43:0] d, bit r, bit s);
      in_valid = 1'b1; in_data = d; rnd_en = r; sat_en = s;
      @(negedge clk);
      cmp(req, "half-up/asym", {ov_a, od_a}, model(d, r, s, 1'b0, 1'b0));
      cmp(req, "half-even/sym", {ov_b, od_b}, model(d, r, s, 1'b1, 1'b1));
      cmp(req, "valid", {44'd0, vl_a & vl_b}, 45'd1);
      @(negedge clk);
   endtask

   function automatic logic [43:0] tie_val(bit odd, bit neg);
      logic [43:0] v;
      v = {$urandom, $urandom};
      v[RP-1:0] = 1'b1 << (RP - 1);
      v[RP] = odd;
      v[43:SP-2] = neg ? '1 : '0;
      return v;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [43:0] held;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R1: reset state
      cmp("R1", "reset", {ov_a, od_a}, 45'd0);
      cmp("R1", "reset alt", {ov_b, od_b}, 45'd0);
      cmp("R1", "reset valid", {44'd0, vl_a | vl_b}, 45'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: pass-through
      sample("R3", 44'hABC_DEF0_1234, 1'b0, 1'b0);
      sample("R3", 44'h7FF_FFFF_FFFF, 1'b0, 1'b0);

      // R6 R7: clamp examples, rounding off
      sample("R6", 44'h592_6AC0_1342, 1'b0, 1'b1);
      sample("R7", 44'hFAD_A38D_2210, 1'b0, 1'b1);
      sample("R7", 44'hFF8_0000_0000, 1'b0, 1'b1);
      sample("R6", 44'h007_FFFF_FFFF, 1'b0, 1'b1);

      // R4 R5: ties with even and odd kept bit, both signs
      for (int i = 0; i < 40; i++) begin
         sample("R5", tie_val(i[0], i[1]), 1'b1, 1'b0);
         sample("R4", tie_val(i[0], i[1]), 1'b1, i[2]);
      end

      // R8: in range before rounding, carried over the limit by it
      sample("R8", (44'd1 << SP) - 44'd1, 1'b1, 1'b1);
      sample("R8", (44'd1 << SP) - (44'd1 << (RP - 1)), 1'b1, 1'b1);
      sample("R8", -((44'd1 << SP) - (44'd1 << (RP - 1))), 1'b1, 1'b1);
      // R6 R7: limits with rounding on
      sample("R6", 44'h7FF_FFFF_FFFF, 1'b1, 1'b1);
      sample("R7", 44'h800_0000_0000, 1'b1, 1'b1);
      // R9: overflow not reported when saturation is off
      sample("R9", 44'h592_6AC0_1342, 1'b1, 1'b0);

      // R2: idle cycle holds outputs and drops valid
      held = od_a;
      in_valid = 1'b0; in_data = 44'h123_4567_89AB; sat_en = 1'b0; rnd_en = 1'b0;
      @(negedge clk);
      cmp("R2", "hold data", {1'b0, od_a}, {1'b0, held});
      cmp("R2", "valid low", {44'd0, vl_a | vl_b}, 45'd0);

      // R2: back-to-back stream, each output one clock after its input
      in_valid = 1'b1;
      for (int i = 0; i < 30; i++) begin
         logic [43:0] d;
         d = {$urandom, $urandom};
         in_data = d; rnd_en = i[0]; sat_en = i[1];
         @(negedge clk);
         cmp("R2", "stream", {ov_a, od_a}, model(d, i[0], i[1], 1'b0, 1'b0));
      end

      // R4 R5 R6 R7 R9: random, magnitude spread by arithmetic shift
      for (int i = 0; i < 3000; i++) begin
         logic [43:0] d;
         d = {$urandom, $urandom};
         d = 44'($signed(d) >>> ($urandom % 12));
         sample("R9", d, bit'($urandom % 2), bit'($urandom % 2));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule